// File: doc/BRIEF.md
# Serial Flash Status-Register Write Engine

This block is the device-side control for status writes in a serial NOR flash. A host frames each command with an active-low chip-select. It shifts the command and data in on a serial clock, either one bit per clock on a single line or one nibble per clock on four lines. The block holds a 24-bit status word. A one-byte enable command arms a write-enable flag. Three write opcodes each load one byte of the status word. Bits that are read-only are left untouched.

An accepted write starts a self-timed busy period of a parameterised number of system clocks. The host sees it as the write-in-progress bit of the status word and can poll that bit at any time. At the end of the busy period the write-enable flag clears. A write is refused in several cases: the frame does not end exactly after the sixteenth bit, the enable flag is clear, a busy period is running, or hardware protect is active. Hardware protect comes from two status bits combined with the write-protect pin.

The serial clock, chip-select and data lines are sampled in the system clock domain, so the system clock must run well above the serial clock.

Top module: `sr_write_engine`

## Requirements
- R1: After reset the whole 24-bit status word reads 0.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable flag, which reads as status bit 1.
- R3: A frame of exactly 16 bits with opcode 0x01, 0x31 or 0x11 loads its data byte into status bits 7:0, 15:8 or 23:16 respectively.
- R4: With `qpi_mode` high, each sclk rising edge shifts four bits from `io_in[3:0]`, bit 3 being the most significant. Each byte takes two clocks, high nibble first. With `qpi_mode` low, one bit is taken from `io_in[0]` per edge, MSB first.
- R5: A status write arriving while the write-enable flag is clear changes nothing.
- R6: A write frame that does not hold exactly 16 bits when chip-select rises is discarded. Examples are 15 bits, 17 bits or 12 bits in four-bit mode. The status word and the enable flag stay as they were.
- R7: An accepted write raises status bit 0 (write in progress) for exactly TW_CYCLES system clocks. It rises on the second clock edge after chip-select goes high. During this time the status word, with the new byte, stays readable on `status`.
- R8: The write-enable flag clears in the same cycle that write-in-progress falls.
- R9: Status bits 20, 19, 17, 16, 15 and 10 are never changed by a write. Bits 1 and 0 only show the enable flag and write-in-progress.
- R10: When status bit 8 is 0, status bit 7 is 1 and `wp_n` is low, status writes are refused.
- R11: Any status write frame that ends while write-in-progress is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select framing each command |
| sclk | input | 1 | Serial clock from host, sampled on its rising edge |
| qpi_mode | input | 1 | 1: four bits per serial clock; 0: one bit |
| io_in | input | 4 | Serial data lines; bit 0 alone is used in one-bit mode |
| wp_n | input | 1 | Active-low write-protect pin |
| status | output | 24 | Status word: bit 0 busy, bit 1 write enable, rest stored |

## Verification
The bench checks the frame-length rule from both sides: 15 and 17 bits, and 12 bits in four-bit mode. A design that decoded on the opcode alone would commit these short or long frames and start a busy period. It times the busy bit cycle by cycle against TW_CYCLES and sends a second write in the middle of the busy period. An off-by-one counter would give the wrong pulse length, and a design without the busy lockout would overwrite the second byte. It writes all ones to every byte to expose the read-only bits. It also toggles `wp_n` around a write once the protect bits are set, to show that only the combination of pin and bits blocks a write.

// File: rtl/sr_write_pkg.sv
package sr_write_pkg;
  localparam int unsigned STAT_W = 24;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_BYTES = STAT_W / BYTE_W;
  localparam int unsigned FRAME_W = 2 * BYTE_W;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WR_B0  = 8'h01;
  localparam logic [7:0] OP_WR_B1  = 8'h31;
  localparam logic [7:0] OP_WR_B2  = 8'h11;

  // bits a write can never alter (bits 1:0 are live flags)
  localparam logic [STAT_W-1:0] RO_MASK = 24'h1B8403;

  typedef enum logic [1:0] {SEL_B0, SEL_B1, SEL_B2, SEL_NONE} byte_sel_e;

  function automatic byte_sel_e decode_sel(input logic [7:0] op);
    case (op)
      OP_WR_B0: return SEL_B0;
      OP_WR_B1: return SEL_B1;
      OP_WR_B2: return SEL_B2;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sr_frame_rx.sv
module sr_frame_rx #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               qpi_mode,
  input  logic [3:0]         io_in,
  output logic               frame_end,
  output logic [CNT_W-1:0]   nbits,
  output logic [FRAME_W-1:0] word
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic               cs_r1, cs_r2, sck_r1, sck_r2, qpi_r1;
  logic [3:0]         io_r1;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               sck_rise;

  assign sck_rise  = sck_r1 & ~sck_r2 & ~cs_r1;
  assign frame_end = cs_r1 & ~cs_r2;
  assign nbits     = cnt_q;
  assign word      = sh_q;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (cs_r2) begin
      cnt_n = '0;
    end else if (sck_rise) begin
      if (qpi_r1) begin
        sh_n  = {sh_q[FRAME_W-5:0], io_r1};
        cnt_n = (cnt_q > CNT_MAX - 4) ? CNT_MAX : cnt_q + 4;
      end else begin
        sh_n  = {sh_q[FRAME_W-2:0], io_r1[0]};
        cnt_n = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_r1  <= 1'b1;
      cs_r2  <= 1'b1;
      sck_r1 <= 1'b0;
      sck_r2 <= 1'b0;
      qpi_r1 <= 1'b0;
      io_r1  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      cs_r1  <= cs_n;
      cs_r2  <= cs_r1;
      sck_r1 <= sclk;
      sck_r2 <= sck_r1;
      qpi_r1 <= qpi_mode;
      io_r1  <= io_in;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
  parameter int unsigned TW_CYCLES = 200,
  localparam int unsigned CW = $clog2(TW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam logic [CW-1:0] LOAD = CW'(TW_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (start) begin
      cnt_n  = LOAD;
      busy_n = 1'b1;
    end else if (done) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end
endmodule

// File: rtl/sr_cmd_exec.sv
module sr_cmd_exec
  import sr_write_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [CNT_W-1:0]   nbits,
  input  logic [FRAME_W-1:0] word,
  input  logic               wp_n,
  input  logic               busy,
  input  logic               done,
  output logic               start,
  output logic               wel,
  output logic [STAT_W-1:2]  stored
);
  logic [STAT_W-1:2] st_q, st_n;
  logic              wel_q, wel_n;
  logic [STAT_W-1:0] cur;
  logic              hw_lock;
  byte_sel_e         sel;

  assign cur     = {st_q, 2'b00};
  assign hw_lock = ~cur[8] & cur[7] & ~wp_n;
  assign sel     = decode_sel(word[FRAME_W-1:BYTE_W]);
  assign wel     = wel_q;
  assign stored  = st_q;

  always_comb begin
    logic [STAT_W-1:0] upd;
    upd   = cur;
    st_n  = st_q;
    wel_n = wel_q;
    start = 1'b0;
    if (done) wel_n = 1'b0;
    if (frame_end && !busy) begin
      if (nbits == CNT_W'(BYTE_W) && word[BYTE_W-1:0] == OP_WREN) begin
        wel_n = 1'b1;
      end else if (nbits == CNT_W'(FRAME_W) && sel != SEL_NONE && wel_q && !hw_lock) begin
        start = 1'b1;
        for (int b = 0; b < int'(N_BYTES); b++) begin
          if (int'(sel) == b) begin
            upd[b*BYTE_W +: BYTE_W] = (cur[b*BYTE_W +: BYTE_W] & RO_MASK[b*BYTE_W +: BYTE_W])
                                    | (word[BYTE_W-1:0] & ~RO_MASK[b*BYTE_W +: BYTE_W]);
          end
        end
        st_n = upd[STAT_W-1:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      wel_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      wel_q <= wel_n;
    end
  end
endmodule

// File: rtl/sr_write_engine.sv
module sr_write_engine
  import sr_write_pkg::*;
#(
  parameter int unsigned TW_CYCLES = 200,
  localparam int unsigned CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              qpi_mode,
  input  logic [3:0]        io_in,
  input  logic              wp_n,
  output logic [STAT_W-1:0] status
);
  logic               frame_end, start, busy, done, wel;
  logic [CNT_W-1:0]   nbits;
  logic [FRAME_W-1:0] word;
  logic [STAT_W-1:2]  stored;

  sr_frame_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .qpi_mode(qpi_mode),
    .io_in(io_in), .frame_end(frame_end), .nbits(nbits), .word(word)
  );

  sr_cmd_exec #(.CNT_W(CNT_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .nbits(nbits), .word(word),
    .wp_n(wp_n), .busy(busy), .done(done), .start(start), .wel(wel), .stored(stored)
  );

  sr_busy_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  assign status = {stored, wel, busy};
endmodule

// File: rtl/sr_write_engine_chk.sv
module sr_write_engine_chk #(
  parameter int unsigned TW_CYCLES = 200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wp_n,
  input logic [23:0] status
);
  int unsigned hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= 0;
    else        hi_len <= status[0] ? hi_len + 1 : 0;
  end

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> status[1]); // R5

  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> hi_len == TW_CYCLES); // R7

  AST_RO_BITS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable({status[20:19], status[17:15], status[10]})); // R9

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> $stable(status[23:2])); // R11

  AST_HW_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !status[8] && status[7] && !status[0]) |=> !status[0]); // R10
endmodule

bind sr_write_engine sr_write_engine_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .status(status)
);

// File: tb/test_sr_write_engine.sv
module test_sr_write_engine;
  localparam int unsigned TW = 100;
  localparam logic [23:0] RO = 24'h1B8403;

  logic        clk, rst_n, cs_n, sclk, qpi_mode, wp_n;
  logic [3:0]  io_in;
  logic [23:0] status;
  logic [23:0] exp_st;
  int checks, errors;
  bit  done_flag;

  sr_write_engine #(.TW_CYCLES(TW)) i_sr_write_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .qpi_mode(qpi_mode),
    .io_in(io_in), .wp_n(wp_n), .status(status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %06h expected %06h", req, got, want);
    end
  endtask

  task automatic send_frame(input logic [7:0] c, input logic [7:0] d, input int nbits, input bit q);
    logic [23:0] w;
    w = {c, d, 8'h00};
    qpi_mode = q;
    cs_n = 1'b0;
    @(negedge clk);
    if (q) begin
      for (int i = 0; i < nbits / 4; i++) begin
        io_in = w[23-4*i -: 4];
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        io_in = {3'b000, w[23-i]};
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
      end
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
  endtask

  function automatic int sel_of(input logic [7:0] op);
    case (op)
      8'h01: return 0;
      8'h31: return 1;
      8'h11: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic wren(input bit q);
    send_frame(8'h06, 8'h00, 8, q);
    repeat (3) @(negedge clk);
    exp_st[1] = 1'b1;
    check("R2 enable flag set", status, exp_st);
  endtask

  // full status write; ok says whether it must be accepted
  task automatic do_write(input string req, input logic [7:0] op, input logic [7:0] d,
                          input bit q, input bit ok);
    int n, b;
    send_frame(op, d, 16, q);
    repeat (2) @(negedge clk);
    if (ok) begin
      b = sel_of(op);
      exp_st[b*8 +: 8] = (exp_st[b*8 +: 8] & RO[b*8 +: 8]) | (d & ~RO[b*8 +: 8]);
      check("R7 busy and enable shown during cycle", {22'd0, status[1:0]}, 24'h3);
      n = 0;
      while (status[0] && n < 5000) begin
        n++;
        @(negedge clk);
      end
      check("R7 busy length", 24'(n), 24'(TW));
      exp_st[1:0] = 2'b00;
      check("R8 enable cleared at end", {23'd0, status[1]}, 24'd0);
      check(req, status, exp_st);
    end else begin
      check({req, " no busy"}, {23'd0, status[0]}, 24'd0);
      repeat (4) @(negedge clk);
      check({req, " unchanged"}, status, exp_st);
    end
  endtask

  task automatic t_reset;
    check("R1 reset value", status, 24'h000000);
  endtask

  task automatic t_no_enable;
    do_write("R5 write without enable", 8'h01, 8'hFC, 1'b0, 1'b0);
  endtask

  task automatic t_spi_bytes;
    wren(1'b0);
    do_write("R3 R9 byte0 all ones", 8'h01, 8'hFF, 1'b0, 1'b1);
    check("R9 byte0 value", {16'd0, status[7:0]}, 24'h0000FC);
    wren(1'b0);
    do_write("R3 R9 byte1 all ones", 8'h31, 8'hFF, 1'b0, 1'b1);
    check("R9 byte1 value", {16'd0, status[15:8]}, 24'h00007B);
    wren(1'b0);
    do_write("R3 R9 byte2 all ones", 8'h11, 8'hFF, 1'b0, 1'b1);
    check("R9 byte2 value", {16'd0, status[23:16]}, 24'h0000E4);
  endtask

  task automatic t_qpi;
    wren(1'b1);
    do_write("R4 four-bit write byte0", 8'h01, 8'h28, 1'b1, 1'b1);
    check("R4 byte0 nibble order", {16'd0, status[7:0]}, 24'h000028);
  endtask

  task automatic t_bad_length;
    wren(1'b0);
    send_frame(8'h01, 8'h00, 15, 1'b0);
    repeat (4) @(negedge clk);
    check("R6 15-bit frame dropped", status, exp_st);
    send_frame(8'h01, 8'h00, 17, 1'b0);
    repeat (4) @(negedge clk);
    check("R6 17-bit frame dropped", status, exp_st);
    send_frame(8'h11, 8'h00, 12, 1'b1);
    repeat (4) @(negedge clk);
    check("R6 12-bit four-bit frame dropped", status, exp_st);
  endtask

  task automatic t_busy_lockout;
    int n;
    send_frame(8'h11, 8'h00, 16, 1'b0);
    repeat (2) @(negedge clk);
    exp_st[23:16] = 8'h00;
    check("R7 busy with new byte visible", status, exp_st | 24'h000001);
    send_frame(8'h31, 8'h00, 16, 1'b1);
    repeat (4) @(negedge clk);
    check("R11 still busy, byte1 kept", status, exp_st | 24'h000001);
    n = 0;
    while (status[0] && n < 5000) begin
      n++;
      @(negedge clk);
    end
    exp_st[1:0] = 2'b00;
    check("R11 write during busy ignored", status, exp_st);
  endtask

  task automatic t_hw_protect;
    wren(1'b0);
    do_write("R3 set bit7", 8'h01, 8'h80, 1'b0, 1'b1);
    wren(1'b0);
    do_write("R3 clear byte1", 8'h31, 8'h00, 1'b0, 1'b1);
    wp_n = 1'b0;
    wren(1'b0);
    do_write("R10 protected write refused", 8'h01, 8'h04, 1'b0, 1'b0);
    wp_n = 1'b1;
    do_write("R10 write allowed with pin high", 8'h01, 8'h04, 1'b0, 1'b1);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done_flag = 1'b0;
    exp_st = 24'h0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; qpi_mode = 1'b0; io_in = 4'h0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_no_enable();
    t_spi_bytes();
    t_qpi();
    t_bad_length();
    t_busy_lockout();
    t_hw_protect();
    finish_run();
  end
endmodule